// File: doc/BRIEF.md
# Jitter Attenuator Elastic Bit Buffer

This block is a one-bit-wide circular elastic store that sits between two clock domains. Serial bits arrive on a jittery write clock and are stored one per cycle into a ring of bit cells. They leave on a smoothed read clock from a second pointer that starts half a ring away. Neither side is ever stalled. Each pointer free-runs on its own clock, so short-term phase wander between the two clocks shows up only as a change in the distance between the pointers.

The write pointer crosses into the read domain as a Gray code through a two-stage synchronizer. The read side then computes the occupancy. When the reader catches the writer, the block reports an underrun; from that point the output would repeat bits it has already sent. When the writer laps the reader, the block reports an overflow; from that point unread bits would be lost. In both cases the read pointer is reloaded to sit half a ring behind the synchronized write pointer. Both flags stay set until the read side pulses a clear.

The ring length is picked at reset from two sizes. Each clock domain has its own reset input, and the block releases each one synchronously to its own clock.

Top module: `jab_elastic_buf`

## Requirements
- R1: `depth_sel` picks the ring length: 0 selects 16 bit cells, 1 selects 32 bit cells.
- R2: The write pointer advances by exactly one cell on every write clock edge outside reset and wraps around the ring. Each incoming bit goes to the next cell.
- R3: Take the write and read resets released together, with the first counted read edge following the first counted write edge within one period. Then the bit captured on the j-th counted write edge appears on `rd_bit` after read edge j + D/2, where D is the ring length. The read pointer starts half a ring away from the write pointer.
- R4: The read pointer advances by one cell on every read clock edge whether or not new data was written. It is only ever replaced by a recentring reload.
- R5: When the occupancy seen in the read domain reaches zero, `underrun` goes high. It stays low while both clocks run at the same rate.
- R6: When the occupancy seen in the read domain reaches the ring length or more, `overflow` goes high and `underrun` is not raised.
- R7: Both flags stay high until a one-cycle `flag_clr` pulse on the read side. When a new slip and a clear arrive in the same cycle, the slip wins.
- R8: After a slip the read pointer is reloaded to half a ring behind the synchronized write pointer. With equal clock rates afterwards, no further slip occurs.
- R9: A change of `depth_sel` outside reset has no effect. The ring length latched at the last reset stays in use until the next reset.
- R10: While in reset, `underrun`, `overflow` and `rd_bit` are 0. Each reset input takes effect immediately and is released two edges of its own clock after it falls.
- R11: Consecutive write pointer values as sent across the clock boundary differ in exactly one bit, including at the ring wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Jittery write clock |
| wr_rst | input | 1 | Write-domain reset, active high |
| wr_bit | input | 1 | Serial data bit, sampled on wr_clk |
| rd_clk | input | 1 | Smoothed read clock |
| rd_rst | input | 1 | Read-domain reset, active high |
| rd_bit | output | 1 | Serial data bit, registered on rd_clk |
| depth_sel | input | 1 | Ring length select (0: 16 cells, 1: 32 cells), latched in reset |
| flag_clr | input | 1 | Read-side pulse that clears the sticky flags |
| underrun | output | 1 | Sticky flag: reader caught the writer |
| overflow | output | 1 | Sticky flag: writer lapped the reader |

## Verification
The data path is driven with three streams at equal clock rates, each exposing a different class of fault:
- A pseudo-random stream exposes swapped or mis-masked cell addresses.
- A strictly alternating stream exposes a latency that is off by one cycle.
- A stream of runs of three equal bits exposes a latency that is off by a few cycles, which alternating data can hide.

Both ring lengths are run. A depth change in mid-stream shows that the old latency is kept until a reset. Underrun is provoked by halting the write clock while the reader runs. Overflow is provoked by halting the read clock long enough for the writer to lap it without aliasing. These two tests tell the two slip directions apart and also cover stickiness, clearing and recentring.

// File: rtl/jab_pkg.sv
`timescale 1ns/1ps
package jab_pkg;

    // log2 of the shallow ring; the deep ring is twice as long
    localparam int unsigned LOG2_SHALLOW = 4;
    localparam int unsigned ADDR_W       = LOG2_SHALLOW + 1;
    localparam int unsigned PTR_W        = LOG2_SHALLOW + 2;
    localparam int unsigned CELLS        = 1 << ADDR_W;
    localparam int unsigned SYNC_STAGES  = 2;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        DEPTH_SHALLOW = 1'b0,
        DEPTH_DEEP    = 1'b1
    } depth_mode_e;

    typedef struct packed {
        logic underrun;
        logic overflow;
    } slip_flags_t;

    // pointers count modulo twice the ring length
    function automatic ptr_t ring_mask(depth_mode_e m);
        return (m == DEPTH_DEEP) ? ptr_t'((1 << PTR_W) - 1)
                                 : ptr_t'((1 << (PTR_W - 1)) - 1);
    endfunction

    function automatic ptr_t depth_of(depth_mode_e m);
        return (m == DEPTH_DEEP) ? ptr_t'(1 << ADDR_W)
                                 : ptr_t'(1 << (ADDR_W - 1));
    endfunction

    function automatic ptr_t half_of(depth_mode_e m);
        return depth_of(m) >> 1;
    endfunction

    function automatic addr_t cell_of(ptr_t p, depth_mode_e m);
        ptr_t sel;
        sel = p & (depth_of(m) - ptr_t'(1));
        return addr_t'(sel);
    endfunction

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/jab_rst_sync.sv
`timescale 1ns/1ps
module jab_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], rst_in};
    end

    // takes hold at once, lets go STAGES edges after the input falls
    assign rst_out = rst_in | (|chain_q);
endmodule

// File: rtl/jab_gray_sync.sv
`timescale 1ns/1ps
module jab_gray_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], gray_in};
        end
    end

    assign gray_out = stage_q[STAGES-1];
endmodule

// File: rtl/jab_wr_side.sv
`timescale 1ns/1ps
module jab_wr_side
    import jab_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  depth_sel,
    input  logic  wr_bit,
    input  addr_t rd_cell,
    output logic  cell_bit,
    output ptr_t  wgray
);
    depth_mode_e     mode_q;
    ptr_t            wptr_q;
    ptr_t            wptr_nxt;
    logic [CELLS-1:0] ring_q;

    assign wptr_nxt = (wptr_q + ptr_t'(1)) & ring_mask(mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= depth_mode_e'(depth_sel);
            wptr_q <= '0;
            wgray  <= '0;
        end else begin
            ring_q[cell_of(wptr_q, mode_q)] <= wr_bit;
            wptr_q <= wptr_nxt;
            wgray  <= bin2gray(wptr_nxt);
        end
    end

    // read port used by the read domain; cells near the reader are settled
    assign cell_bit = ring_q[rd_cell];

    // R2
    wptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wptr_q == (($past(wptr_q) + ptr_t'(1)) & ring_mask(mode_q)));

    // R11
    gray_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(wgray ^ $past(wgray)) == 1);

    // R9
    wr_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/jab_rd_side.sv
`timescale 1ns/1ps
module jab_rd_side
    import jab_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        depth_sel,
    input  ptr_t        wgray_sync,
    input  logic        flag_clr,
    input  logic        cell_bit,
    output addr_t       rd_cell,
    output logic        rd_bit,
    output slip_flags_t flags
);
    depth_mode_e mode_q;
    ptr_t        rptr_q;
    ptr_t        wbin;
    ptr_t        occ;
    logic        hit_empty;
    logic        hit_full;
    logic        slip;

    assign wbin      = gray2bin(wgray_sync);
    assign occ       = (wbin - rptr_q) & ring_mask(mode_q);
    assign hit_empty = (occ == '0);
    assign hit_full  = (occ >= depth_of(mode_q));
    assign slip      = hit_empty | hit_full;
    assign rd_cell   = cell_of(rptr_q, mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= depth_mode_e'(depth_sel);
            rptr_q <= (ptr_t'(0) - half_of(depth_mode_e'(depth_sel)))
                      & ring_mask(depth_mode_e'(depth_sel));
            rd_bit <= 1'b0;
            flags  <= '0;
        end else begin
            rd_bit <= cell_bit;
            if (slip) begin
                rptr_q <= (wbin - half_of(mode_q)) & ring_mask(mode_q);
            end else begin
                rptr_q <= (rptr_q + ptr_t'(1)) & ring_mask(mode_q);
            end
            flags.underrun <= hit_empty | (flags.underrun & ~flag_clr);
            flags.overflow <= hit_full  | (flags.overflow & ~flag_clr);
        end
    end

    // R4
    rptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !slip |=> rptr_q == (($past(rptr_q) + ptr_t'(1)) & ring_mask(mode_q)));

    // R7
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flags.underrun && !flag_clr |=> flags.underrun);

    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flags.overflow && !flag_clr |=> flags.overflow);

    // R8
    recentre_chk: assert property (@(posedge clk) disable iff (rst)
        slip |=> (occ != '0) && (occ < depth_of(mode_q)));

    // R9
    rd_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/jab_elastic_buf.sv
`timescale 1ns/1ps
module jab_elastic_buf
    import jab_pkg::*;
(
    input  logic wr_clk,
    input  logic wr_rst,
    input  logic wr_bit,
    input  logic rd_clk,
    input  logic rd_rst,
    output logic rd_bit,
    input  logic depth_sel,
    input  logic flag_clr,
    output logic underrun,
    output logic overflow
);
    logic        wr_rst_s;
    logic        rd_rst_s;
    ptr_t        wgray;
    ptr_t        wgray_sync;
    addr_t       rd_cell;
    logic        cell_bit;
    slip_flags_t flags;

    jab_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
        .clk(wr_clk), .rst_in(wr_rst), .rst_out(wr_rst_s)
    );

    jab_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
        .clk(rd_clk), .rst_in(rd_rst), .rst_out(rd_rst_s)
    );

    jab_wr_side u_wr (
        .clk(wr_clk), .rst(wr_rst_s), .depth_sel(depth_sel),
        .wr_bit(wr_bit), .rd_cell(rd_cell), .cell_bit(cell_bit),
        .wgray(wgray)
    );

    jab_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
        .clk(rd_clk), .rst(rd_rst_s), .gray_in(wgray), .gray_out(wgray_sync)
    );

    jab_rd_side u_rd (
        .clk(rd_clk), .rst(rd_rst_s), .depth_sel(depth_sel),
        .wgray_sync(wgray_sync), .flag_clr(flag_clr), .cell_bit(cell_bit),
        .rd_cell(rd_cell), .rd_bit(rd_bit), .flags(flags)
    );

    assign underrun = flags.underrun;
    assign overflow = flags.overflow;
endmodule

// File: tb/jab_elastic_buf_test.sv
`timescale 1ns/1ps
module jab_elastic_buf_test;
    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1;
    logic wr_bit = 0, depth_sel = 0, flag_clr = 0;
    logic rd_bit, underrun, overflow;
    bit   wrun = 1, rrun = 1, done = 0;
    int   errs = 0, checks = 0;
    bit   sb[$];

    jab_elastic_buf uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_bit(wr_bit),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_bit(rd_bit),
        .depth_sel(depth_sel), .flag_clr(flag_clr),
        .underrun(underrun), .overflow(overflow)
    );

    // 250 MHz on both sides, read clock trailing by 1 ns
    initial forever begin #2; if (wrun) wr_clk = ~wr_clk; end
    initial begin #1; forever begin #2; if (rrun) rd_clk = ~rd_clk; end end

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    // R10: reset holds outputs low, released on a write-clock falling edge
    task automatic do_reset(logic sel);
        wr_rst = 1; rd_rst = 1; depth_sel = sel;
        repeat (4) @(negedge wr_clk);
        chk("R10", underrun, 1'b0, "underrun in reset");
        chk("R10", overflow, 1'b0, "overflow in reset");
        chk("R10", rd_bit, 1'b0, "rd_bit in reset");
        wr_rst = 0; rd_rst = 0;
    endtask

    // scoreboard: driver pushes, monitor pops after D/2 read edges (R2, R3, R1)
    task automatic run_stream(int d, int n, int pat, bit flip_sel);
        fork
            begin
                logic [15:0] lfsr = 16'hACE1;
                bit b;
                repeat (2) @(posedge wr_clk);
                for (int j = 0; j < n; j++) begin
                    @(negedge wr_clk);
                    case (pat)
                        0: b = lfsr[0];
                        1: b = j[0];
                        default: b = ((j / 3) % 2) == 1;
                    endcase
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    wr_bit = b;
                    sb.push_back(b);
                end
            end
            begin
                repeat (2 + d / 2) @(posedge rd_clk);
                for (int j = 0; j < n; j++) begin
                    bit e;
                    @(posedge rd_clk); #1;
                    e = sb.pop_front();
                    chk(flip_sel ? "R9" : "R3", rd_bit, e, $sformatf("bit %0d depth %0d", j, d));
                end
            end
            begin
                if (flip_sel) begin
                    repeat (20) @(posedge rd_clk);
                    #1 depth_sel = ~depth_sel;
                end
            end
        join
    endtask

    task automatic rd_wait(int n);
        repeat (n) begin @(posedge rd_clk); #1; end
    endtask

    initial begin
        // R1 shallow ring, three patterns
        do_reset(1'b0); run_stream(16, 80, 0, 1'b0);
        do_reset(1'b0); run_stream(16, 60, 1, 1'b0);
        do_reset(1'b0); run_stream(16, 60, 2, 1'b0);
        // R1 deep ring
        do_reset(1'b1); run_stream(32, 100, 0, 1'b0);
        do_reset(1'b1); run_stream(32, 60, 2, 1'b0);
        // R9: depth change mid-run keeps the shallow latency
        do_reset(1'b0); run_stream(16, 80, 0, 1'b1);
        chk("R5", underrun, 1'b0, "no underrun at equal rates");
        chk("R6", overflow, 1'b0, "no overflow at equal rates");

        // R4/R5: halt writer, reader keeps going and catches up
        @(posedge wr_clk); #1 wrun = 0;
        rd_wait(24);
        chk("R5", underrun, 1'b1, "underrun after writer halt");
        chk("R6", overflow, 1'b0, "overflow after writer halt");
        @(posedge rd_clk); wrun = 1;
        rd_wait(20);
        chk("R7", underrun, 1'b1, "underrun sticky");
        @(posedge rd_clk); #1 flag_clr = 1;
        @(posedge rd_clk); #1 flag_clr = 0;
        chk("R7", underrun, 1'b0, "underrun cleared");
        rd_wait(60);
        chk("R8", underrun, 1'b0, "no slip after recentre");
        chk("R8", overflow, 1'b0, "no overflow after recentre");

        // R6: halt reader so the writer laps it (fresh shallow ring)
        do_reset(1'b0);
        rd_wait(30);
        @(posedge rd_clk); #1 rrun = 0;
        repeat (16) @(posedge wr_clk);
        @(negedge wr_clk); rrun = 1;
        rd_wait(6);
        chk("R6", overflow, 1'b1, "overflow after reader halt");
        chk("R6", underrun, 1'b0, "underrun after reader halt");
        rd_wait(30);
        chk("R7", overflow, 1'b1, "overflow sticky");
        @(posedge rd_clk); #1 flag_clr = 1;
        @(posedge rd_clk); #1 flag_clr = 0;
        chk("R7", overflow, 1'b0, "overflow cleared");
        rd_wait(50);
        chk("R8", overflow, 1'b0, "no overflow after recentre");
        // R10: reset after activity
        do_reset(1'b1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errs++;
            $display("FAIL R1..all watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule